// File: doc/BRIEF.md
# Periodic Down-Counter Compare Timer

This block is a 32-bit down-counting timer. A simple register bus gives access to five word registers: control, status, load, compare and count. The count advances on a tick. A tick is made from one of three external clock-enable strobes, chosen by a source field, and divided by a 12-bit prescaler. When the counter reaches zero it either reloads from the load register or wraps to all-ones, depending on a mode bit.

Each time the counter steps onto the compare value, a sticky status flag is set. The flag drives a level interrupt when the compare interrupt and the timer are both enabled. Software can restart the count when it enables the timer, overwrite the running count through the load register, and issue a soft reset that keeps the enable-class bits.

Top module: `cdt_top`

## Requirements
- R1: After hardware reset the registers read as follows: control 0, status 0, compare 0, load 0xFFFFFFFF and count 0xFFFFFFFF. irq_o is low.
- R2: A control write keeps only bits [25:0]. Bits [31:26] always read 0.
- R3: The word offsets are control 0, status 1, load 2, compare 3 and count 4. The count register is read-only. A write to offset 4 or to any offset of 5 or above has no effect. A read of an offset of 5 or above returns 0.
- R4: With reload mode set (control bit 3), each tick decrements the count. A tick at count 0 loads the load register value.
- R5: The compare flag (status bit 0) is set by a tick that moves the count onto the compare value. This happens even when the compare interrupt enable (control bit 2) is clear.
- R6: Writing status with bit 0 set clears the flag. Writing status with bit 0 clear leaves the flag unchanged.
- R7: irq_o is high exactly when the flag, the compare interrupt enable and the timer enable (control bit 0) are all set.
- R8: A load register write made while immediate-overwrite (control bit 17) is set also loads the written value into the count, whatever the reload mode.
- R9: With reload mode clear, a tick at count 0 wraps the count to 0xFFFFFFFF.
- R10: The prescaler field (control [15:4]) makes one tick per field value plus one selected strobes.
- R11: When the enable bit goes from 0 to 1, the count is reloaded only if enable-mode (control bit 1) is set. Otherwise the count keeps its value.
- R12: Writing control with bit 16 set performs a soft reset. Of the written value it keeps only bits 0, 1, 18, 19, 20 and 21. It also clears the flag, sets load to 0xFFFFFFFF and compare to 0, and the count stops.
- R13: The source field (control [25:24]) selects the strobe. Value 0 means no ticks. Value n selects src_stb_i[n-1]. Strobes that are not selected have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Bus access request |
| we_i | input | 1 | Write enable for the access |
| addr_i | input | 3 | Word offset of the register |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for addr_i (combinational) |
| src_stb_i | input | 3 | Clock-enable strobes for sources 1 to 3 |
| irq_o | output | 1 | Compare interrupt, level |

## Verification
The hardest case to reach from the ports is the set of wraps and rollovers at count zero. These include the reload from the load register, the wrap to all-ones, and the compare hit on the step that reaches the compare value. With the reset load value, a free-running count would need billions of ticks to get there. The bench reaches these cases by writing small load values with immediate-overwrite set, then giving exact numbers of single-cycle strobes. Prescaler phase and source selection are driven the same way, so every expected count follows from the number of strobes given.

// File: rtl/cdt_pkg.sv
package cdt_pkg;
  localparam int unsigned DW     = 32;
  localparam int unsigned PW     = 12;
  localparam int unsigned NSRC   = 3;
  localparam int unsigned CR_W   = 26;
  localparam int unsigned B_EN   = 0;
  localparam int unsigned B_EMOD = 1;
  localparam int unsigned B_CIE  = 2;
  localparam int unsigned B_RLD  = 3;
  localparam int unsigned B_PRE  = 4;
  localparam int unsigned B_SWR  = 16;
  localparam int unsigned B_IOV  = 17;
  localparam int unsigned B_DBG  = 18;
  localparam int unsigned B_WAIT = 19;
  localparam int unsigned B_DOZE = 20;
  localparam int unsigned B_STOP = 21;
  localparam int unsigned B_SRC  = 24;

  typedef enum logic [2:0] {
    A_CTRL = 3'd0,
    A_STAT = 3'd1,
    A_LOAD = 3'd2,
    A_CMP  = 3'd3,
    A_CNT  = 3'd4
  } addr_e;

  function automatic logic [DW-1:0] keep_mask();
    logic [DW-1:0] m;
    m = '0;
    m[B_EN] = 1'b1;
    m[B_EMOD] = 1'b1;
    m[B_DBG] = 1'b1;
    m[B_WAIT] = 1'b1;
    m[B_DOZE] = 1'b1;
    m[B_STOP] = 1'b1;
    return m;
  endfunction
endpackage

// File: rtl/cdt_tick.sv
module cdt_tick
  import cdt_pkg::*;
#(
  parameter int unsigned P_W = PW,
  parameter int unsigned N_SRC = NSRC
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic [1:0]       src_i,
  input  logic [P_W-1:0]   presc_i,
  input  logic [N_SRC-1:0] stb_i,
  output logic             tick_o
);
  logic [P_W-1:0] pre_q;
  logic run, sel;

  always_comb begin
    sel = 1'b0;
    for (int i = 0; i < N_SRC; i++)
      if (32'(src_i) == i + 1) sel = stb_i[i];
  end

  assign run    = en_i && (src_i != 2'd0);
  assign tick_o = run && sel && (pre_q == presc_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      pre_q <= '0;
    else if (!run)    pre_q <= '0;
    else if (tick_o)  pre_q <= '0;
    else if (sel)     pre_q <= pre_q + 1'b1;
  end

  // R13 / R10: a tick needs an enabled, selected strobe
  p_tick_src_r13: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_o |-> (en_i && src_i != 2'd0 && stb_i != '0));
  p_pre_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run && !sel && $past(run)) |=> $stable(pre_q));
endmodule

// File: rtl/cdt_count.sv
module cdt_count
  import cdt_pkg::*;
#(
  parameter int unsigned W = DW
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         tick_i,
  input  logic         rld_i,
  input  logic [W-1:0] lr_i,
  input  logic [W-1:0] cmp_i,
  input  logic         load_i,
  input  logic [W-1:0] load_val_i,
  output logic [W-1:0] cnt_o,
  output logic         hit_o
);
  logic [W-1:0] cnt_q, nxt;

  assign nxt   = (cnt_q == '0) ? (rld_i ? lr_i : '1) : cnt_q - 1'b1;
  assign hit_o = tick_i && (nxt == cmp_i);
  assign cnt_o = cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '1;
    else if (load_i) cnt_q <= load_val_i;
    else if (tick_i) cnt_q <= nxt;
  end

  p_dec_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && !load_i && cnt_q != '0) |=> cnt_q == $past(cnt_q) - 1'b1);
  p_reload_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && !load_i && cnt_q == '0 && rld_i) |=> cnt_q == $past(lr_i));
  p_wrap_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && !load_i && cnt_q == '0 && !rld_i) |=> cnt_q == '1);
  p_hold_r13: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!tick_i && !load_i) |=> $stable(cnt_q));
  p_load_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> cnt_q == $past(load_val_i));
endmodule

// File: rtl/cdt_regs.sv
module cdt_regs
  import cdt_pkg::*;
#(
  parameter int unsigned W = DW
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         req_i,
  input  logic         we_i,
  input  logic [2:0]   addr_i,
  input  logic [W-1:0] wdata_i,
  input  logic [W-1:0] cnt_i,
  input  logic         hit_i,
  output logic [W-1:0] rdata_o,
  output logic [W-1:0] cr_o,
  output logic [W-1:0] lr_o,
  output logic [W-1:0] cmp_o,
  output logic         flag_o,
  output logic         load_o,
  output logic [W-1:0] load_val_o
);
  localparam logic [W-1:0] CR_MASK = W'((64'd1 << CR_W) - 64'd1);
  localparam logic [W-1:0] KEEP    = keep_mask();

  logic [W-1:0] cr_q, lr_q, cmp_q, cr_new;
  logic flag_q, wr, wr_cr, wr_st, wr_lr, wr_cmp, swr, rise_en;

  assign wr      = req_i && we_i;
  assign wr_cr   = wr && addr_i == A_CTRL;
  assign wr_st   = wr && addr_i == A_STAT;
  assign wr_lr   = wr && addr_i == A_LOAD;
  assign wr_cmp  = wr && addr_i == A_CMP;
  assign cr_new  = wdata_i & CR_MASK;
  assign swr     = cr_new[B_SWR];
  assign rise_en = !cr_q[B_EN] && cr_new[B_EN];

  always_comb begin
    load_o = 1'b0;
    load_val_o = wdata_i;
    if (wr_cr && !swr && rise_en && cr_new[B_EMOD]) begin
      load_o = 1'b1;
      load_val_o = cr_new[B_RLD] ? lr_q : '1;
    end else if (wr_lr && cr_q[B_IOV]) begin
      load_o = 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cr_q <= '0;
      lr_q <= '1;
      cmp_q <= '0;
      flag_q <= 1'b0;
    end else if (wr_cr && swr) begin
      cr_q <= cr_new & KEEP;
      lr_q <= '1;
      cmp_q <= '0;
      flag_q <= 1'b0;
    end else begin
      if (wr_cr) cr_q <= cr_new;
      if (wr_lr) lr_q <= wdata_i;
      if (wr_cmp) cmp_q <= wdata_i;
      if (hit_i) flag_q <= 1'b1;
      else if (wr_st && wdata_i[0]) flag_q <= 1'b0;
    end
  end

  always_comb begin
    unique case (addr_i)
      A_CTRL:  rdata_o = cr_q;
      A_STAT:  rdata_o = {{(W-1){1'b0}}, flag_q};
      A_LOAD:  rdata_o = lr_q;
      A_CMP:   rdata_o = cmp_q;
      A_CNT:   rdata_o = cnt_i;
      default: rdata_o = '0;
    endcase
  end

  assign cr_o = cr_q;
  assign lr_o = lr_q;
  assign cmp_o = cmp_q;
  assign flag_o = flag_q;

  p_flag_rise_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(flag_q) |-> $past(hit_i));
  p_flag_clr_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_st && !wdata_i[0] && flag_q && !wr_cr) |=> flag_q);
  p_swr_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_cr && swr) |=> (lr_q == '1 && cmp_q == '0 && !flag_q && !cr_q[B_SWR]
                        && cr_q[B_SRC+:2] == 2'd0));
  p_upper_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_cr |=> cr_q[W-1:CR_W] == '0);
endmodule

// File: rtl/cdt_top.sv
module cdt_top
  import cdt_pkg::*;
(
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            req_i,
  input  logic            we_i,
  input  logic [2:0]      addr_i,
  input  logic [DW-1:0]   wdata_i,
  output logic [DW-1:0]   rdata_o,
  input  logic [NSRC-1:0] src_stb_i,
  output logic            irq_o
);
  logic [DW-1:0] cr, lr, cmp, cnt, load_val;
  logic flag, load, tick, hit;

  cdt_regs #(.W(DW)) u_regs (
    .clk_i(clk_i), .rst_ni(rst_ni), .req_i(req_i), .we_i(we_i),
    .addr_i(addr_i), .wdata_i(wdata_i), .cnt_i(cnt), .hit_i(hit),
    .rdata_o(rdata_o), .cr_o(cr), .lr_o(lr), .cmp_o(cmp), .flag_o(flag),
    .load_o(load), .load_val_o(load_val)
  );

  cdt_tick #(.P_W(PW), .N_SRC(NSRC)) u_tick (
    .clk_i(clk_i), .rst_ni(rst_ni), .en_i(cr[B_EN]), .src_i(cr[B_SRC+:2]),
    .presc_i(cr[B_PRE+:PW]), .stb_i(src_stb_i), .tick_o(tick)
  );

  cdt_count #(.W(DW)) u_count (
    .clk_i(clk_i), .rst_ni(rst_ni), .tick_i(tick), .rld_i(cr[B_RLD]),
    .lr_i(lr), .cmp_i(cmp), .load_i(load), .load_val_i(load_val),
    .cnt_o(cnt), .hit_o(hit)
  );

  assign irq_o = flag && cr[B_CIE] && cr[B_EN];

  p_irq_off_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(cr[B_EN]) |-> !irq_o);
  p_irq_rise_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(irq_o) |-> ($past(hit) || $past(req_i && we_i && addr_i == A_CTRL)));
endmodule

// File: tb/cdt_top_bench.sv
`timescale 1ns/1ps
module cdt_top_bench;
  logic clk = 1'b0, rst_n = 1'b0, req = 1'b0, we = 1'b0;
  logic [2:0] addr = '0;
  logic [31:0] wdata = '0, rdata;
  logic [2:0] stb = '0;
  logic irq;
  int n_chk = 0, n_fail = 0;

  always #4 clk = ~clk;

  cdt_top u_cdt_top (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .we_i(we), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .src_stb_i(stb), .irq_o(irq)
  );

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(logic [2:0] a, logic [31:0] d);
    @(negedge clk);
    req = 1'b1; we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    req = 1'b0; we = 1'b0;
  endtask

  task automatic rd_chk(string tag, logic [2:0] a, logic [31:0] exp);
    addr = a;
    #1;
    chk(tag, rdata, exp);
  endtask

  task automatic pulse(logic [2:0] m, int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      stb = m;
    end
    @(negedge clk);
    stb = '0;
  endtask

  task automatic t_reset();
    rd_chk("R1 ctrl", 3'd0, 32'h0);
    rd_chk("R1 stat", 3'd1, 32'h0);
    rd_chk("R1 load", 3'd2, 32'hFFFF_FFFF);
    rd_chk("R1 cmp", 3'd3, 32'h0);
    rd_chk("R1 cnt", 3'd4, 32'hFFFF_FFFF);
    chk("R1 irq", 32'(irq), 32'h0);
  endtask

  task automatic t_map();
    wr(3'd0, 32'hFC00_00F0);
    rd_chk("R2 ctrl mask", 3'd0, 32'h0000_00F0);
    wr(3'd4, 32'h1234_5678);
    rd_chk("R3 cnt read-only", 3'd4, 32'hFFFF_FFFF);
    wr(3'd6, 32'h5555_5555);
    rd_chk("R3 unmapped read", 3'd5, 32'h0);
    rd_chk("R3 unmapped write no effect", 3'd2, 32'hFFFF_FFFF);
    wr(3'd0, 32'h0);
  endtask

  task automatic t_reload();
    wr(3'd2, 32'd5);
    wr(3'd3, 32'd3);
    wr(3'd0, 32'h0100_000F);
    rd_chk("R11 enable restart", 3'd4, 32'd5);
    pulse(3'b001, 2);
    rd_chk("R4 decrement", 3'd4, 32'd3);
    rd_chk("R5 flag set", 3'd1, 32'd1);
    chk("R7 irq high", 32'(irq), 32'd1);
    pulse(3'b001, 3);
    rd_chk("R4 at zero", 3'd4, 32'd0);
    pulse(3'b001, 1);
    rd_chk("R4 reload", 3'd4, 32'd5);
  endtask

  task automatic t_clear();
    wr(3'd1, 32'h0);
    rd_chk("R6 write 0 keeps", 3'd1, 32'd1);
    wr(3'd1, 32'h1);
    rd_chk("R6 write 1 clears", 3'd1, 32'd0);
    chk("R7 irq low after clear", 32'(irq), 32'd0);
  endtask

  task automatic t_gate();
    wr(3'd0, 32'h0100_0009);
    rd_chk("R11 no restart when already on", 3'd4, 32'd5);
    pulse(3'b001, 2);
    rd_chk("R5 flag with irq disabled", 3'd1, 32'd1);
    chk("R7 irq masked", 32'(irq), 32'd0);
    wr(3'd0, 32'h0100_000D);
    chk("R7 irq enabled", 32'(irq), 32'd1);
    wr(3'd0, 32'h0100_0004);
    chk("R7 irq off when disabled", 32'(irq), 32'd0);
    rd_chk("R7 flag kept", 3'd1, 32'd1);
    wr(3'd1, 32'h1);
  endtask

  task automatic t_overwrite();
    wr(3'd0, 32'h0102_0001);
    rd_chk("R11 resume without enable-mode", 3'd4, 32'd3);
    wr(3'd2, 32'd1);
    rd_chk("R8 overwrite", 3'd4, 32'd1);
    pulse(3'b001, 2);
    rd_chk("R9 wrap", 3'd4, 32'hFFFF_FFFF);
  endtask

  task automatic t_presc();
    wr(3'd0, 32'h0100_0021);
    pulse(3'b001, 2);
    rd_chk("R10 no tick before N+1", 3'd4, 32'hFFFF_FFFF);
    pulse(3'b001, 1);
    rd_chk("R10 tick at N+1", 3'd4, 32'hFFFF_FFFE);
  endtask

  task automatic t_src();
    wr(3'd0, 32'h0300_0001);
    pulse(3'b011, 2);
    rd_chk("R13 unselected strobe", 3'd4, 32'hFFFF_FFFE);
    pulse(3'b100, 1);
    rd_chk("R13 selected strobe", 3'd4, 32'hFFFF_FFFD);
    wr(3'd0, 32'h0000_0001);
    pulse(3'b111, 3);
    rd_chk("R13 source none", 3'd4, 32'hFFFF_FFFD);
  endtask

  task automatic t_swr();
    wr(3'd3, 32'hFFFF_FFFC);
    wr(3'd0, 32'h0100_0001);
    pulse(3'b001, 1);
    rd_chk("R5 hit before soft reset", 3'd1, 32'd1);
    wr(3'd0, 32'h0121_000F);
    rd_chk("R12 ctrl kept bits", 3'd0, 32'h0020_0003);
    rd_chk("R12 stat", 3'd1, 32'd0);
    rd_chk("R12 load", 3'd2, 32'hFFFF_FFFF);
    rd_chk("R12 cmp", 3'd3, 32'd0);
    pulse(3'b111, 2);
    rd_chk("R12 count stopped", 3'd4, 32'hFFFF_FFFC);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_map();
    t_reload();
    t_clear();
    t_gate();
    t_overwrite();
    t_presc();
    t_src();
    t_swr();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule